// File: doc/BRIEF.md
# In-band XON/XOFF Flow Control Engine

This block carries out character-based (software-style) flow control in hardware for one serial port. On the receive side it inspects every received byte, recognises the configured resume (XON) and pause (XOFF) codes, and removes them from the stream. Recognised codes set or release a transmit-hold signal that tells the serializer to stop taking queued data. All other bytes are passed on toward the receive FIFO.

On the transmit side it watches the receive FIFO fill level against two watermarks. It requests injection of a pause code when the FIFO fills and a resume code when the FIFO drains. The serializer takes an injected character at its next character boundary, in place of queued data, even while the transmitter is held.

Two configurable code pairs exist. The transmit and receive sides each choose the first pair, the second pair, or a two-character sequence that uses both pairs. An option lets any received character release a hold. A status word and a one-cycle interrupt report hold conditions and received flow codes.

Top module: `xonxoff_flow_engine`

## Requirements
- R1: After reset, tx_hold, inject_req, fwd_valid and irq are 0, status is 0x00 and irq_id is 0x01.
- R2: With flow_mode[1:0]=10, a received byte equal to pause1 sets tx_hold and status bit 3 from the next cycle. A byte equal to resume1 clears them. Neither byte is forwarded. Any other byte appears on fwd_data with fwd_valid one cycle after rx_valid.
- R3: With flow_mode[1:0]=01, only pause2/resume2 are recognised, and pause1 is forwarded as data.
- R4: With flow_mode[1:0]=11, pause1 immediately followed by pause2 holds, and resume1 immediately followed by resume2 releases. If the byte after a stored first code does not complete the pair, the stored code is forwarded one cycle after that byte arrives, and the byte itself is forwarded one cycle later. Received bytes are at least two cycles apart.
- R5: With flow_mode[1:0]=00, no byte is recognised. Setting that field to 00 clears tx_hold on the next cycle.
- R6: When xon_any_en is 1, any received byte releases tx_hold. An unrecognised byte is still forwarded.
- R7: When irq_en is 1, a recognised flow code gives irq=1 and irq_id=0x10 for one cycle, one cycle after the byte. Otherwise irq_id is 0x01 and irq stays 0.
- R8: With flow_mode[3:2] not 00, rx_level reaching wm_high raises inject_req with the pause code on the next cycle. This happens once per crossing. Status bit 4 is set once the code has been taken.
- R9: After a pause has been sent, rx_level at or below wm_low raises inject_req with the resume code. Status bit 4 clears once that code has been taken. A level above wm_low sends nothing.
- R10: With flow_mode[3:2]=11, the first-pair code is injected first, and then the second-pair code.
- R11: inject_req and inject_char stay steady until tx_slot takes them. Injection is requested and taken while tx_hold is 1.
- R12: With flow_mode[3:2]=00, no character is injected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_level | input | 7 | Receive FIFO fill level |
| flow_mode | input | 4 | [3:2] transmit pair select, [1:0] receive pair select (00 none, 10 pair 1, 01 pair 2, 11 both) |
| xon_any_en | input | 1 | Any byte releases hold |
| irq_en | input | 1 | Flow-code interrupt enable |
| resume1 | input | 8 | First-pair resume code |
| resume2 | input | 8 | Second-pair resume code |
| pause1 | input | 8 | First-pair pause code |
| pause2 | input | 8 | Second-pair pause code |
| wm_high | input | 7 | High watermark |
| wm_low | input | 7 | Low watermark |
| tx_slot | input | 1 | Serializer at character boundary |
| fwd_valid | output | 1 | Byte for receive FIFO valid |
| fwd_data | output | 8 | Byte for receive FIFO |
| tx_hold | output | 1 | Transmitter held by received pause |
| inject_req | output | 1 | Flow character waiting to be sent |
| inject_char | output | 8 | Character to inject |
| status | output | 8 | Bit 3 hold by received pause, bit 4 pause sent, other bits 0 |
| irq | output | 1 | Flow-code interrupt pulse |
| irq_id | output | 8 | 0x10 during irq, else 0x01 |

## Verification
The assertions take for granted that rx_valid never arrives on two consecutive cycles, because that is what gives the forwarding path room to release a stored first code. They also assume the watermarks satisfy wm_low < wm_high. Every byte the stimulus sends, random or directed, is followed by an idle cycle, and the watermarks stay fixed at values that obey that order. Random bytes avoid the configured codes wherever the expected result is plain forwarding.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'b00,
      SEL_P2   = 2'b01,
      SEL_P1   = 2'b10,
      SEL_BOTH = 2'b11
   } pair_sel_e;

   localparam logic [7:0] IRQ_ID_FLOW = 8'h10;
   localparam logic [7:0] IRQ_ID_IDLE = 8'h01;
   localparam int ST_HELD_BIT = 3;
   localparam int ST_SENT_BIT = 4;
endpackage

// File: rtl/xfc_rx_match.sv
module xfc_rx_match
   import xfc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  pair_sel_e     sel,
   input  logic [DW-1:0] on1,
   input  logic [DW-1:0] on2,
   input  logic [DW-1:0] off1,
   input  logic [DW-1:0] off2,
   output logic          got_on,
   output logic          got_off,
   output logic          fwd_valid,
   output logic [DW-1:0] fwd_data
);
   logic          pend_v, spill_v;
   logic [DW-1:0] pend_d, spill_d;
   logic          pair_on, pair_off, is_on, is_off, starts, new_fwd, flush;

   always_comb begin
      pair_on  = rx_valid && pend_v && sel == SEL_BOTH && pend_d == on1  && rx_data == on2;
      pair_off = rx_valid && pend_v && sel == SEL_BOTH && pend_d == off1 && rx_data == off2;
      is_on  = 1'b0;
      is_off = 1'b0;
      starts = 1'b0;
      case (sel)
         SEL_P1:   begin is_on = rx_data == on1; is_off = rx_data == off1; end
         SEL_P2:   begin is_on = rx_data == on2; is_off = rx_data == off2; end
         SEL_BOTH: starts = (rx_data == on1) || (rx_data == off1);
         default:  ;
      endcase
      got_on  = rx_valid && (pair_on || (is_on && !(pair_off)));
      got_off = rx_valid && (pair_off || (is_off && !(pair_on)));
      flush   = rx_valid && pend_v && !pair_on && !pair_off;
      new_fwd = rx_valid && !pair_on && !pair_off && !is_on && !is_off && !starts;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v <= 1'b0; pend_d <= '0;
         spill_v <= 1'b0; spill_d <= '0;
         fwd_valid <= 1'b0; fwd_data <= '0;
      end else if (rx_valid) begin
         pend_v <= !pair_on && !pair_off && starts;
         if (starts) pend_d <= rx_data;
         if (flush) begin
            fwd_valid <= 1'b1;
            fwd_data  <= pend_d;
            spill_v   <= new_fwd;
            spill_d   <= rx_data;
         end else begin
            fwd_valid <= new_fwd;
            fwd_data  <= rx_data;
            spill_v   <= 1'b0;
         end
      end else begin
         fwd_valid <= spill_v;
         fwd_data  <= spill_d;
         spill_v   <= 1'b0;
      end
   end

   // R4 input spacing assumed by the forwarding path
   p_rx_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R2 forwarded bytes only follow a received or spilled byte
   p_fwd_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> ($past(rx_valid) || $past(spill_v)));
   // R4 a broken pair always emits the stored code next cycle
   p_flush_emits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && pend_v && !got_on && !got_off) |=> fwd_valid);
endmodule

// File: rtl/xfc_hold_ctrl.sv
module xfc_hold_ctrl
   import xfc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       got_on,
   input  logic       got_off,
   input  logic       rx_any,
   input  logic       any_en,
   input  logic       rx_off,
   input  logic       irq_en,
   output logic       tx_hold,
   output logic       irq,
   output logic [7:0] irq_id
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_hold <= 1'b0;
         irq     <= 1'b0;
      end else begin
         if (rx_off)                           tx_hold <= 1'b0;
         else if (got_off)                     tx_hold <= 1'b1;
         else if (got_on || (any_en && rx_any)) tx_hold <= 1'b0;
         irq <= irq_en && (got_on || got_off);
      end
   end

   assign irq_id = irq ? IRQ_ID_FLOW : IRQ_ID_IDLE;

   // R5 receive recognition off releases the hold
   p_off_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_off |=> !tx_hold);
   // R7 interrupt needs enable and a received byte
   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(irq_en) && $past(rx_any)));
endmodule

// File: rtl/xfc_tx_inject.sv
module xfc_tx_inject
   import xfc_pkg::*;
#(
   parameter int DW = 8,
   parameter int LW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] level,
   input  logic [LW-1:0] wm_high,
   input  logic [LW-1:0] wm_low,
   input  pair_sel_e     sel_tx,
   input  logic [DW-1:0] on1,
   input  logic [DW-1:0] on2,
   input  logic [DW-1:0] off1,
   input  logic [DW-1:0] off2,
   input  logic          tx_slot,
   output logic          inject_req,
   output logic [DW-1:0] inject_char,
   output logic          off_sent
);
   logic      busy, kind_off, idx, armed_off, last;
   pair_sel_e seq_sel;
   logic      trig_off, trig_on;

   always_comb begin
      trig_off = !busy && !armed_off && sel_tx != SEL_NONE && level >= wm_high;
      trig_on  = !busy &&  armed_off && sel_tx != SEL_NONE && level <= wm_low;
      last     = (seq_sel != SEL_BOTH) || idx;
      if (seq_sel == SEL_P2 || (seq_sel == SEL_BOTH && idx))
         inject_char = kind_off ? off2 : on2;
      else
         inject_char = kind_off ? off1 : on1;
   end

   assign inject_req = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; kind_off <= 1'b0; idx <= 1'b0;
         armed_off <= 1'b0; off_sent <= 1'b0; seq_sel <= SEL_NONE;
      end else if (busy) begin
         if (tx_slot) begin
            if (last) begin
               busy     <= 1'b0;
               idx      <= 1'b0;
               off_sent <= kind_off;
            end else begin
               idx <= 1'b1;
            end
         end
      end else if (trig_off || trig_on) begin
         busy      <= 1'b1;
         kind_off  <= trig_off;
         armed_off <= trig_off;
         seq_sel   <= sel_tx;
         idx       <= 1'b0;
      end
   end

   // R11 a pending character waits unchanged for its slot
   p_req_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_req && !tx_slot) |=> (inject_req && $stable(inject_char)));
   // R12 injection only starts with a transmit pair selected
   p_no_inject_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inject_req) |-> $past(sel_tx != SEL_NONE));
endmodule

// File: rtl/xonxoff_flow_engine.sv
module xonxoff_flow_engine
   import xfc_pkg::*;
#(
   parameter int DW         = 8,
   parameter int FIFO_DEPTH = 64,
   localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic [LW-1:0] rx_level,
   input  logic [3:0]    flow_mode,
   input  logic          xon_any_en,
   input  logic          irq_en,
   input  logic [DW-1:0] resume1,
   input  logic [DW-1:0] resume2,
   input  logic [DW-1:0] pause1,
   input  logic [DW-1:0] pause2,
   input  logic [LW-1:0] wm_high,
   input  logic [LW-1:0] wm_low,
   input  logic          tx_slot,
   output logic          fwd_valid,
   output logic [DW-1:0] fwd_data,
   output logic          tx_hold,
   output logic          inject_req,
   output logic [DW-1:0] inject_char,
   output logic [7:0]    status,
   output logic          irq,
   output logic [7:0]    irq_id
);
   generate
      if (DW < 5) begin : g_bad_dw
         $error("DW must be at least 5");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
   endgenerate

   pair_sel_e sel_rx, sel_tx;
   logic      got_on, got_off, off_sent;

   assign sel_rx = pair_sel_e'(flow_mode[1:0]);
   assign sel_tx = pair_sel_e'(flow_mode[3:2]);

   xfc_rx_match #(.DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .sel(sel_rx), .on1(resume1), .on2(resume2), .off1(pause1), .off2(pause2),
      .got_on(got_on), .got_off(got_off), .fwd_valid(fwd_valid), .fwd_data(fwd_data)
   );

   xfc_hold_ctrl u_hold (
      .clk(clk), .rst_n(rst_n), .got_on(got_on), .got_off(got_off),
      .rx_any(rx_valid), .any_en(xon_any_en), .rx_off(sel_rx == SEL_NONE),
      .irq_en(irq_en), .tx_hold(tx_hold), .irq(irq), .irq_id(irq_id)
   );

   xfc_tx_inject #(.DW(DW), .LW(LW)) u_tx (
      .clk(clk), .rst_n(rst_n), .level(rx_level), .wm_high(wm_high), .wm_low(wm_low),
      .sel_tx(sel_tx), .on1(resume1), .on2(resume2), .off1(pause1), .off2(pause2),
      .tx_slot(tx_slot), .inject_req(inject_req), .inject_char(inject_char),
      .off_sent(off_sent)
   );

   always_comb begin
      status = '0;
      status[ST_HELD_BIT] = tx_hold;
      status[ST_SENT_BIT] = off_sent;
   end

   // R8 watermark order assumed by the injection logic
   p_wm_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wm_low < wm_high);
endmodule

// File: tb/xonxoff_flow_engine_tb_top.sv
module xonxoff_flow_engine_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic [6:0] rx_level = '0;
   logic [3:0] flow_mode = '0;
   logic       xon_any_en = 1'b0, irq_en = 1'b0, tx_slot = 1'b0;
   logic [7:0] resume1 = 8'h11, resume2 = 8'h91, pause1 = 8'h13, pause2 = 8'h93;
   logic [6:0] wm_high = 7'd12, wm_low = 7'd4;
   logic       fwd_valid, tx_hold, inject_req, irq;
   logic [7:0] fwd_data, inject_char, status, irq_id;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   xonxoff_flow_engine dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_level(rx_level), .flow_mode(flow_mode), .xon_any_en(xon_any_en),
      .irq_en(irq_en), .resume1(resume1), .resume2(resume2), .pause1(pause1),
      .pause2(pause2), .wm_high(wm_high), .wm_low(wm_low), .tx_slot(tx_slot),
      .fwd_valid(fwd_valid), .fwd_data(fwd_data), .tx_hold(tx_hold),
      .inject_req(inject_req), .inject_char(inject_char), .status(status),
      .irq(irq), .irq_id(irq_id)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_code(input logic [7:0] b);
      return b == resume1 || b == resume2 || b == pause1 || b == pause2;
   endfunction

   function automatic logic [7:0] exp_status(input bit held, input bit sent);
      return {3'b000, sent, held, 3'b000};
   endfunction

   // one byte, then sample on the negedge after it is registered
   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_data = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic slot();
      @(negedge clk); tx_slot = 1'b1;
      @(negedge clk); tx_slot = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R1 hold", tx_hold, 0); chk("R1 inject", inject_req, 0);
      chk("R1 status", status, 0); chk("R1 fwd", fwd_valid, 0);
      chk("R1 irq", irq, 0); chk("R1 irq_id", irq_id, 8'h01);
      rst_n = 1'b1;

      // R2 first pair, with interrupt (R7)
      flow_mode = 4'b0010; irq_en = 1'b1;
      send(8'h13);
      chk("R2 hold", tx_hold, 1); chk("R2 status", status, exp_status(1, 0));
      chk("R2 no fwd", fwd_valid, 0); chk("R7 irq", irq, 1); chk("R7 id", irq_id, 8'h10);
      @(negedge clk);
      chk("R7 pulse", irq, 0); chk("R7 idle id", irq_id, 8'h01);
      send(8'h11);
      chk("R2 release", tx_hold, 0); chk("R2 no fwd resume", fwd_valid, 0);

      // R3 second pair
      flow_mode = 4'b0001;
      send(8'h13);
      chk("R3 fwd pause1", fwd_valid, 1); chk("R3 data", fwd_data, 8'h13); chk("R3 no hold", tx_hold, 0);
      send(8'h93); chk("R3 hold", tx_hold, 1);
      send(8'h91); chk("R3 release", tx_hold, 0);

      // R2 random data forwarding
      flow_mode = 4'b0010;
      for (int i = 0; i < 40; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         if (is_code(b)) b = 8'h41;
         send(b);
         chk("R2 rand fwd", fwd_valid, 1); chk("R2 rand data", fwd_data, b);
         chk("R2 rand hold", tx_hold, 0);
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end

      // R4 two-character sequences
      flow_mode = 4'b0011;
      send(8'h13); chk("R4 first stored", fwd_valid, 0); chk("R4 not yet", tx_hold, 0);
      send(8'h93); chk("R4 hold", tx_hold, 1); chk("R4 no fwd", fwd_valid, 0);
      send(8'h11); chk("R4 stored", fwd_valid, 0);
      send(8'h41);
      chk("R4 flush v", fwd_valid, 1); chk("R4 flush d", fwd_data, 8'h11); chk("R4 still held", tx_hold, 1);
      @(negedge clk);
      chk("R4 spill v", fwd_valid, 1); chk("R4 spill d", fwd_data, 8'h41);
      send(8'h11); send(8'h91); chk("R4 release", tx_hold, 0);

      // R6 any byte releases
      flow_mode = 4'b0010;
      send(8'h13); chk("R6 held", tx_hold, 1);
      xon_any_en = 1'b1;
      send(8'h55); chk("R6 release", tx_hold, 0); chk("R6 fwd", fwd_data, 8'h55);
      xon_any_en = 1'b0;

      // R5 recognition off
      send(8'h13); chk("R5 held", tx_hold, 1);
      @(negedge clk); flow_mode = 4'b0000;
      @(negedge clk); chk("R5 release", tx_hold, 0);
      send(8'h13); chk("R5 fwd", fwd_valid, 1); chk("R5 data", fwd_data, 8'h13); chk("R5 no hold", tx_hold, 0);

      // R7 disabled interrupt
      irq_en = 1'b0; flow_mode = 4'b0010;
      send(8'h13); chk("R7 masked", irq, 0); chk("R7 masked id", irq_id, 8'h01);
      send(8'h11);

      // R8 / R9 first-pair injection
      flow_mode = 4'b1000;
      @(negedge clk); rx_level = 7'd12;
      @(negedge clk); chk("R8 req", inject_req, 1); chk("R8 char", inject_char, 8'h13);
      repeat (3) @(negedge clk);
      chk("R11 steady", inject_req, 1); chk("R11 char", inject_char, 8'h13);
      slot(); chk("R8 taken", inject_req, 0); chk("R8 sent bit", status, exp_status(0, 1));
      rx_level = 7'd14; repeat (4) @(negedge clk); chk("R8 once", inject_req, 0);
      rx_level = 7'd5; repeat (3) @(negedge clk); chk("R9 above low", inject_req, 0);
      rx_level = 7'd4; @(negedge clk); chk("R9 req", inject_req, 1); chk("R9 char", inject_char, 8'h11);
      slot(); chk("R9 taken", inject_req, 0); chk("R9 sent clr", status, 0);

      // R10 both pairs
      flow_mode = 4'b1100;
      rx_level = 7'd12; @(negedge clk); chk("R10 first", inject_char, 8'h13);
      slot(); chk("R10 req2", inject_req, 1); chk("R10 second", inject_char, 8'h93);
      slot(); chk("R10 done", inject_req, 0); chk("R10 status", status, exp_status(0, 1));
      rx_level = 7'd0; @(negedge clk); chk("R10 on first", inject_char, 8'h11);
      slot(); chk("R10 on second", inject_char, 8'h91);
      slot(); chk("R10 on done", inject_req, 0);

      // R11 inject while held
      flow_mode = 4'b1010;
      send(8'h13); chk("R11 held", tx_hold, 1);
      rx_level = 7'd20; @(negedge clk);
      chk("R11 req held", inject_req, 1); chk("R11 char held", inject_char, 8'h13);
      slot(); chk("R11 taken", inject_req, 0); chk("R11 status", status, exp_status(1, 1));
      rx_level = 7'd0; @(negedge clk); slot(); send(8'h11);

      // R12 transmit off
      flow_mode = 4'b0010;
      rx_level = 7'd30; repeat (4) @(negedge clk); chk("R12 none", inject_req, 0);
      rx_level = 7'd0; repeat (2) @(negedge clk);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule